// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block is the slave end of an 8-bit multiplexed address/data bus. It turns the bus strobes into a latched register address, single-cycle read and write enables for a small register file, and the output enable of the shared data lines. All bus pins are treated as asynchronous. They pass through synchronizer chains into the system clock domain, and every action starts from an edge detected there.

A static mode input picks the bus style. In split-strobe mode, `ds` is an active-low read strobe and `rw` is an active-low write strobe that commits data on its rising edge. In direction-line mode, `rw` gives the transfer direction (high means read) and `ds` qualifies the transfer: a read starts on the rising edge of `ds` and a write commits on its falling edge. The address is captured on every falling edge of `as`, whether or not the chip is selected. Reads and writes need chip select, and the bus is never driven without it.

Top module: `mbus_slave_if`

## Requirements
- R1: On a falling edge of `as`, the value on `ad_in` is loaded into `reg_addr` whatever `cs_n` is doing. `reg_addr` shows the new value after the third rising clock edge that follows the `as` change, and otherwise holds its value.
- R2: Split-strobe mode (`mode_dir`=0) read: while selected, a falling `ds` raises `ad_oe` and gives one `reg_rd_en` pulse, both after the third rising clock edge. While `ad_oe` is high, `ad_out` equals `reg_rdata`.
- R3: Split-strobe mode write: while selected, a rising `rw` gives one `reg_wr_en` pulse after the third rising clock edge. During that pulse, `reg_wdata` holds the `ad_in` value present at the `rw` edge.
- R4: Direction-line mode (`mode_dir`=1) read: while selected and with `rw` high, a rising `ds` raises `ad_oe` and gives one `reg_rd_en` pulse. While `ad_oe` is high, `ad_out` equals `reg_rdata`.
- R5: Direction-line mode write: while selected and with `rw` low, a falling `ds` gives one `reg_wr_en` pulse carrying the `ad_in` value present at that edge.
- R6: With `cs_n` high, no strobe produces `reg_wr_en` or `reg_rd_en`, and `ad_oe` stays 0.
- R7: `ad_oe` drops combinationally, in the same instant, when the read strobe returns to its inactive level or when `cs_n` goes high. The inactive level of the read strobe is `ds` high in split-strobe mode and `ds` low in direction-line mode. While `ad_oe` is 0, `ad_out` is all zeros.
- R8: While `rst_n` is low, bus cycles have no effect: no enables, `ad_oe` is 0 and `reg_addr` is 0.
- R9: Each enable pulse lasts exactly one clock cycle, and `reg_wr_en` and `reg_rd_en` are never high together.
- R10: In direction-line mode, the wrong pairing of direction and edge does nothing. A rising `ds` with `rw` low starts no read, and a falling `ds` with `rw` high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dir | input | 1 | Bus style: 0 split strobes, 1 direction line |
| cs_n | input | 1 | Chip select, active low |
| as | input | 1 | Address strobe; falling edge captures the address |
| ds | input | 1 | Data strobe |
| rw | input | 1 | Write strobe (mode 0) or direction (mode 1) |
| ad_in | input | DATA_W | Multiplexed address/data bus, inbound |
| ad_out | output | DATA_W | Read data toward the bus |
| ad_oe | output | 1 | Output enable for the bus drivers |
| reg_addr | output | ADDR_W | Latched register address |
| reg_wr_en | output | 1 | Single-cycle register write enable |
| reg_wdata | output | DATA_W | Write data for the register file |
| reg_rd_en | output | 1 | Single-cycle register read enable |
| reg_rdata | input | DATA_W | Read data from the register file |

## Verification
Every edge-driven result is due at the third rising clock edge after the pin changes: two synchronizer flops, then one registered action. The bench drives each pin on a falling clock edge and samples on falling edges. It checks that the result is still absent two falling edges after the stimulus and present on the third. For enable pulses it also checks that the pulse is gone on the fourth. The output-enable release is combinational, so it is checked one time step after the strobe or select is released, with no clock edge in between.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic {
      BUS_SPLIT   = 1'b0,
      BUS_DIRLINE = 1'b1
   } bus_mode_e;

   localparam int SIG_AS  = 0;
   localparam int SIG_DS  = 1;
   localparam int SIG_RW  = 2;
   localparam int SIG_CS  = 3;
   localparam int NUM_SIG = 4;

   typedef struct packed {
      logic as_fall;
      logic ds_fall;
      logic ds_rise;
      logic rw_rise;
   } bus_edges_t;
endpackage

// File: rtl/mbus_edge_sync.sv
module mbus_edge_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] lvl_d,
   output logic             valid
);
   localparam int FILL  = STAGES + 1;
   localparam int CNT_W = $clog2(FILL + 1);

   if (STAGES < 2) begin : g_bad_stages
      $error("mbus_edge_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mbus_edge_sync: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din[b]};
      end
      assign lvl[b] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end

   logic [CNT_W-1:0] fill_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         fill_cnt <= '0;
      else if (fill_cnt != CNT_W'(FILL))  fill_cnt <= fill_cnt + 1'b1;
   end
   assign valid = (fill_cnt == CNT_W'(FILL));

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid); // R8
endmodule

// File: rtl/mbus_delay_line.sv
module mbus_delay_line #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 1) begin : g_bad_stages
      $error("mbus_delay_line: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[s] <= '0;
         else if (s == 0) pipe[s] <= din;
         else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] din,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (capture) addr <= din;
   end

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(addr)); // R1
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
   import mbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_dir,
   input  logic              sel,
   input  logic              ds_lvl,
   input  logic              rw_lvl,
   input  bus_edges_t        edges,
   input  logic [DATA_W-1:0] data_in,
   output logic              wr_en,
   output logic [DATA_W-1:0] wdata,
   output logic              rd_en,
   output logic              oe_q
);
   bus_mode_e mode;
   logic      rd_start, wr_start, rd_strobe_on;

   assign mode = bus_mode_e'(mode_dir);

   always_comb begin
      if (mode == BUS_SPLIT) begin
         wr_start     = sel & edges.rw_rise;
         rd_start     = sel & edges.ds_fall & ~wr_start;
         rd_strobe_on = ~ds_lvl;
      end else begin
         wr_start     = sel & edges.ds_fall & ~rw_lvl;
         rd_start     = sel & edges.ds_rise & rw_lvl;
         rd_strobe_on = ds_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en <= 1'b0;
         rd_en <= 1'b0;
         wdata <= '0;
         oe_q  <= 1'b0;
      end else begin
         wr_en <= wr_start;
         rd_en <= rd_start;
         if (wr_start) wdata <= data_in;
         if (rd_start)                      oe_q <= 1'b1;
         else if (!sel || !rd_strobe_on)    oe_q <= 1'b0;
      end
   end

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R9
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en); // R9
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en)); // R9
   AST_RD_OPENS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> oe_q); // R2
   AST_NO_SEL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !wr_en && !rd_en); // R6
endmodule

// File: rtl/mbus_slave_if.sv
module mbus_slave_if
   import mbus_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_dir,
   input  logic              cs_n,
   input  logic              as,
   input  logic              ds,
   input  logic              rw,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_rd_en,
   input  logic [DATA_W-1:0] reg_rdata
);
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("mbus_slave_if: ADDR_W cannot exceed DATA_W");
   end

   logic [NUM_SIG-1:0] raw, lvl, lvl_d;
   logic               sync_ok, sel, oe_q;
   logic [DATA_W-1:0]  ad_d;
   bus_edges_t         edges;

   assign raw[SIG_AS] = as;
   assign raw[SIG_DS] = ds;
   assign raw[SIG_RW] = rw;
   assign raw[SIG_CS] = cs_n;

   mbus_edge_sync #(.WIDTH(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw),
      .lvl(lvl), .lvl_d(lvl_d), .valid(sync_ok)
   );

   mbus_delay_line #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_data (
      .clk(clk), .rst_n(rst_n), .din(ad_in), .dout(ad_d)
   );

   assign edges.as_fall = sync_ok &  lvl_d[SIG_AS] & ~lvl[SIG_AS];
   assign edges.ds_fall = sync_ok &  lvl_d[SIG_DS] & ~lvl[SIG_DS];
   assign edges.ds_rise = sync_ok & ~lvl_d[SIG_DS] &  lvl[SIG_DS];
   assign edges.rw_rise = sync_ok & ~lvl_d[SIG_RW] &  lvl[SIG_RW];
   assign sel           = ~lvl[SIG_CS] & ~lvl_d[SIG_CS];

   mbus_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .capture(edges.as_fall),
      .din(ad_d[ADDR_W-1:0]), .addr(reg_addr)
   );

   mbus_cycle_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_dir(mode_dir), .sel(sel),
      .ds_lvl(lvl[SIG_DS]), .rw_lvl(lvl[SIG_RW]), .edges(edges),
      .data_in(ad_d), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .rd_en(reg_rd_en), .oe_q(oe_q)
   );

   assign ad_oe  = oe_q & rst_n & ~cs_n & (mode_dir ? ds : ~ds);
   assign ad_out = ad_oe ? reg_rdata : '0;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !ad_oe && !reg_wr_en && !reg_rd_en); // R8
   AST_ADDR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !edges.as_fall |=> $stable(reg_addr)); // R1
endmodule

// File: tb/tb_mbus_slave_if.sv
module tb_mbus_slave_if;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_dir = 1'b0;
   logic       cs_n = 1'b1, as = 1'b0, ds = 1'b1, rw = 1'b1;
   logic [7:0] ad_in = '0;
   logic [7:0] ad_out, reg_addr, reg_wdata, reg_rdata;
   logic       ad_oe, reg_wr_en, reg_rd_en;

   int nchk = 0, nerr = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic [7:0] last_waddr, last_wdata;
   bit done = 0;

   always #10 clk = ~clk;

   assign reg_rdata = reg_addr ^ 8'hA5;

   mbus_slave_if dut (
      .clk(clk), .rst_n(rst_n), .mode_dir(mode_dir), .cs_n(cs_n),
      .as(as), .ds(ds), .rw(rw), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
   );

   always @(negedge clk) begin
      if (reg_wr_en) begin
         wr_cnt++;
         last_waddr = reg_addr;
         last_wdata = reg_wdata;
      end
      if (reg_rd_en) rd_cnt++;
      if (reg_wr_en && reg_rd_en) begin
         nchk++; nerr++;
         $display("FAIL R9: wr/rd together act=1 exp=0");
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_idle(input logic m);
      mode_dir = m; cs_n = 1'b1; as = 1'b0; rw = 1'b1; ds = m ? 1'b0 : 1'b1;
      wait_neg(4);
   endtask

   task automatic addr_phase(input logic [7:0] a, input bit timed, input bit live);
      logic [7:0] old;
      ad_in = a; as = 1'b1; wait_neg(3);
      old = reg_addr;
      as = 1'b0;
      if (timed) begin
         wait_neg(2);
         chk(reg_addr == old, "R1 early", reg_addr, old);
         wait_neg(1);
         chk(reg_addr == (live ? a : 8'h00), "R1 due", reg_addr, live ? a : 8'h00);
         wait_neg(1);
      end else wait_neg(4);
   endtask

   task automatic write_op(input logic m, input logic [7:0] a, input logic [7:0] d,
                           input bit sel, input bit live);
      int w0 = wr_cnt, r0 = rd_cnt;
      bit exp = sel && live;
      addr_phase(a, 1'b1, live);
      ad_in = d; cs_n = ~sel;
      if (m == 1'b0) begin
         rw = 1'b0; wait_neg(3);
         rw = 1'b1;
      end else begin
         rw = 1'b0; wait_neg(3);
         ds = 1'b1; wait_neg(3);          // rising ds with rw low: R10
         chk(rd_cnt == r0 && !ad_oe, "R10 no read", rd_cnt - r0, 0);
         ds = 1'b0;
      end
      wait_neg(2);
      chk(reg_wr_en == 1'b0, m ? "R5 early" : "R3 early", reg_wr_en, 0);
      wait_neg(1);
      chk(reg_wr_en == exp, m ? "R5 due" : "R3 due", reg_wr_en, exp);
      wait_neg(1);
      chk(reg_wr_en == 1'b0, "R9 pulse end", reg_wr_en, 0);
      chk(wr_cnt - w0 == int'(exp), sel ? "R9 count" : "R6 count", wr_cnt - w0, exp);
      if (exp) chk({last_waddr, last_wdata} == {a, d}, m ? "R5 data" : "R3 data",
                   {last_waddr, last_wdata}, {a, d});
      go_idle(m);
   endtask

   task automatic read_op(input logic m, input logic [7:0] a, input bit sel,
                          input bit live, input bit drop_cs);
      int r0 = rd_cnt, w0 = wr_cnt;
      bit exp = sel && live;
      addr_phase(a, 1'b0, live);
      cs_n = ~sel; rw = 1'b1; wait_neg(3);
      ds = m ? 1'b1 : 1'b0;
      wait_neg(2);
      chk(ad_oe == 1'b0, m ? "R4 early" : "R2 early", ad_oe, 0);
      wait_neg(1);
      chk(ad_oe == exp, sel ? (m ? "R4 oe" : "R2 oe") : "R6 oe", ad_oe, exp);
      chk(ad_out == (exp ? (a ^ 8'hA5) : 8'h00), m ? "R4 data" : "R2 data", ad_out,
          exp ? (a ^ 8'hA5) : 8'h00);
      wait_neg(2);
      chk(rd_cnt - r0 == int'(exp), sel ? "R9 rd count" : "R6 rd count", rd_cnt - r0, exp);
      if (drop_cs) cs_n = 1'b1;
      else         ds = m ? 1'b0 : 1'b1;
      #1;
      chk(ad_oe == 1'b0 && ad_out == 8'h00, "R7 release", ad_oe, 0);
      ds = m ? 1'b0 : 1'b1;
      wait_neg(5);
      chk(wr_cnt == w0, "R10 no write", wr_cnt - w0, 0);
      go_idle(m);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: act=timeout exp=finish");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      wait_neg(3);
      chk(!ad_oe && !reg_wr_en && !reg_rd_en && reg_addr == 8'h00, "R8 reset state",
          {ad_oe, reg_wr_en, reg_rd_en}, 0);
      // accesses during reset are ignored
      write_op(1'b0, 8'h3C, 8'h5A, 1'b1, 1'b0);
      read_op(1'b0, 8'h3C, 1'b1, 1'b0, 1'b0);
      chk(reg_addr == 8'h00, "R8 addr", reg_addr, 0);
      rst_n = 1'b1;
      go_idle(1'b0);
      for (int m = 0; m < 2; m++) begin
         go_idle(m[0]);
         for (int i = 0; i < 16; i++) begin
            logic [7:0] a = 8'(i * 17) ^ (m[0] ? 8'h3C : 8'h00);
            logic [7:0] d = ~a + 8'(i);
            bit sel = (i % 5) != 3;
            write_op(m[0], a, d, sel, 1'b1);
            read_op(m[0], a ^ 8'h0F, sel, 1'b1, (i % 2) == 1);
         end
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule